// File: doc/BRIEF.md
# Slot-Weighted Dispatch Group Tracker

This block follows how full the instruction dispatch group currently being formed is. A group holds a small number of issue slots. Each instruction uses one, two or four of them, depending on its class and on whether it is a record form that also sets a condition field. Some classes may only open a group. When such an instruction arrives while the group already holds something, the block raises a hint so a scheduler can pick another candidate. If the instruction is emitted anyway, it starts a fresh group.

A scheduler drives one instruction descriptor per cycle on the descriptor pins. It pulses `ins_valid` when that instruction is emitted, or `nop_valid` when a padding no-op is emitted instead. It pulses `query_valid` to ask how many no-ops must be placed ahead of the descriptor. The descriptor's load-after-store flag marks a load that depends on a store already in the group, which would cause an expensive replay. The answer arrives on `pad_count` one cycle after the query, together with `pad_valid`. A mode pin selects a machine that has a single no-op that terminates the group.

Every input is a single-cycle strobe with no back-pressure. The tracker accepts one event on every clock, so there is no ready signal. If `ins_valid` and `nop_valid` are both high in the same cycle, the instruction is taken and the no-op is dropped. A query may share a cycle with either kind of emit. The query is answered from the slot count held before that cycle's emit.

Top module: `dgt_tracker`

## Requirements
- R1: A synchronous active-high `rst` sets `slot_count`, `branch_count`, `pad_count` and `pad_valid` to zero at the next clock edge.
- R2: The 4-bit `ins_class` code sets the slot weight as follows. Codes 1 (divide) and 2 (update-form or algebraic load/store) weigh 2. Codes 3 (indexed update form), 4 (reserve or conditional load/store) and 5 (move to condition register) weigh 4. Every other code, including 0, 6 (condition logical), 7 (condition read) and 8 (special-register write), weighs 1.
- R3: When `ins_record` is high, an instruction whose class weight is 1 weighs 2. Weights of 2 and 4 are unchanged.
- R4: `must_lead` is high, combinationally from the descriptor, when the weight is above 1 or the class code is 6, 7 or 8.
- R5: `prefer_other` is high exactly when `must_lead` is high and `slot_count` is nonzero.
- R6: An emitted instruction empties the group in two cases: when `slot_count` is 5, or when `ins_branch` is high and `branch_count` is nonzero. In both cases the slot and branch counts become 0 and the instruction itself is not counted.
- R7: Otherwise, an emitted instruction with `must_lead` high and a nonzero `slot_count` first empties the group. Its weight then becomes the new slot count, and the branch count becomes 1 if it is a branch and 0 if not.
- R8: Otherwise, an emitted instruction adds its weight to `slot_count`, which saturates at 7, and a branch adds 1 to `branch_count`, which saturates at 3.
- R9: On the cycle after a `query_valid` pulse, `pad_valid` is 1. `pad_count` is then 1 in terminating mode, or 5 minus the slot count in the other mode, when `ins_after_store` was high and the slot count was below 6. In every other case `pad_count` is 0. Without a query, both are 0 on the next cycle.
- R10: An emitted no-op empties the group when `term_nop_mode` is high or `slot_count` is 6. Otherwise it adds one slot, saturating at 7.
- R11: With neither strobe high, the counts hold. With both high, the no-op has no effect and the instruction is applied alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_nop_mode | input | 1 | 1 selects a single group-terminating no-op |
| ins_valid | input | 1 | The descriptor is emitted this cycle |
| ins_class | input | 4 | Instruction class code |
| ins_record | input | 1 | Record form (also sets a condition field) |
| ins_branch | input | 1 | Instruction is a branch |
| ins_after_store | input | 1 | Load depending on a store already in the group |
| nop_valid | input | 1 | A padding no-op is emitted this cycle |
| query_valid | input | 1 | Request a padding count for the descriptor |
| must_lead | output | 1 | Descriptor may only open a group |
| prefer_other | output | 1 | Descriptor would force a group break now |
| slot_count | output | 3 | Slots used in the current group |
| branch_count | output | 2 | Branches in the current group |
| pad_valid | output | 1 | `pad_count` answers the previous cycle's query |
| pad_count | output | 3 | Number of no-ops needed ahead of the descriptor |

## Verification
The assertions assume the descriptor pins are stable and known whenever a strobe or a query is high. They also assume `term_nop_mode` is steady within the cycle it is sampled. The bench drives every input half a clock away from the sampling edge, so this always holds. The stimulus covers every class code with and without the record flag, and every slot count from 0 to 7 in both padding modes. It also includes a long pseudo-random mix in which both strobes are sometimes high together, so the precedence and saturation paths are reached.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN       = 4'd0,
    CLS_DIVIDE      = 4'd1,
    CLS_UPD_MEM     = 4'd2,
    CLS_IDX_UPD_MEM = 4'd3,
    CLS_RESV_COND   = 4'd4,
    CLS_MOVE_TO_CR  = 4'd5,
    CLS_CR_LOGIC    = 4'd6,
    CLS_CR_READ     = 4'd7,
    CLS_SPR_WRITE   = 4'd8
  } op_class_e;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic             record;
    logic             branch;
    logic             after_store;
  } ins_desc_t;

  function automatic int unsigned class_weight(input logic [CLS_W-1:0] c);
    case (c)
      CLS_DIVIDE, CLS_UPD_MEM:                        return 2;
      CLS_IDX_UPD_MEM, CLS_RESV_COND, CLS_MOVE_TO_CR: return 4;
      default:                                        return 1;
    endcase
  endfunction

  function automatic logic class_forced_lead(input logic [CLS_W-1:0] c);
    case (c)
      CLS_CR_LOGIC, CLS_CR_READ, CLS_SPR_WRITE: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dgt_classify.sv
module dgt_classify
  import dgt_pkg::*;
#(
  parameter int SLOT_W = 3
) (
  input  logic [CLS_W-1:0]  cls,
  input  logic              record,
  output logic [SLOT_W-1:0] weight,
  output logic              lead
);
  int unsigned base_w;
  int unsigned eff_w;

  always_comb begin
    base_w = class_weight(cls);
    eff_w  = (base_w == 1 && record) ? 2 : base_w;
    weight = SLOT_W'(eff_w);
    lead   = (eff_w > 1) || class_forced_lead(cls);
  end
endmodule

// File: rtl/dgt_group_state.sv
module dgt_group_state #(
  parameter int SLOT_W       = 3,
  parameter int BR_W         = 2,
  parameter int FULL_AT      = 5,
  parameter int NOP_CLEAR_AT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              term_mode,
  input  logic              ins_v,
  input  logic [SLOT_W-1:0] ins_weight,
  input  logic              ins_lead,
  input  logic              ins_branch,
  input  logic              nop_v,
  output logic [SLOT_W-1:0] slot_q,
  output logic [BR_W-1:0]   br_q
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] FULL_V   = SLOT_W'(FULL_AT);
  localparam logic [SLOT_W-1:0] NOPCLR_V = SLOT_W'(NOP_CLEAR_AT);
  localparam logic [SLOT_W-1:0] ONE_S    = SLOT_W'(1);
  localparam logic [BR_W-1:0]   BR_MAX   = '1;

  function automatic logic [SLOT_W-1:0] slot_sat(input logic [SLOT_W-1:0] a,
                                                 input logic [SLOT_W-1:0] b);
    logic [SLOT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SLOT_W] ? SLOT_MAX : s[SLOT_W-1:0];
  endfunction

  logic [SLOT_W-1:0] slot_d, base_s;
  logic [BR_W-1:0]   br_d, base_b;
  logic              wrap_group, restart;

  always_comb begin
    slot_d     = slot_q;
    br_d       = br_q;
    base_s     = slot_q;
    base_b     = br_q;
    wrap_group = (slot_q == FULL_V) || (ins_branch && br_q != '0);
    restart    = ins_lead && slot_q != '0;
    if (ins_v) begin
      if (wrap_group) begin
        slot_d = '0;
        br_d   = '0;
      end else begin
        if (restart) begin
          base_s = '0;
          base_b = '0;
        end
        slot_d = slot_sat(base_s, ins_weight);
        br_d   = (ins_branch && base_b != BR_MAX) ? base_b + 1'b1 : base_b;
      end
    end else if (nop_v) begin
      if (term_mode || slot_q == NOPCLR_V) begin
        slot_d = '0;
        br_d   = '0;
      end else begin
        slot_d = slot_sat(slot_q, ONE_S);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      br_q   <= '0;
    end else begin
      slot_q <= slot_d;
      br_q   <= br_d;
    end
  end

  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
    ins_v && slot_q == FULL_V |=> slot_q == '0 && br_q == '0);  // R6
  AST_SECOND_BRANCH: assert property (@(posedge clk) disable iff (rst)
    ins_v && ins_branch && br_q != '0 |=> slot_q == '0 && br_q == '0);  // R6
  AST_LEAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    ins_v && ins_lead && slot_q != '0 && slot_q != FULL_V && !(ins_branch && br_q != '0)
    |=> slot_q == $past(ins_weight));  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    slot_q == SLOT_MAX && !ins_v && nop_v && !term_mode |=> slot_q == SLOT_MAX);  // R8
  AST_TERM_NOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !ins_v && nop_v && term_mode |=> slot_q == '0 && br_q == '0);  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ins_v && !nop_v |=> $stable(slot_q) && $stable(br_q));  // R11
endmodule

// File: rtl/dgt_pad_calc.sv
module dgt_pad_calc #(
  parameter int SLOT_W       = 3,
  parameter int FILL_TO      = 5,
  parameter int NOP_CLEAR_AT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              term_mode,
  input  logic              query_v,
  input  logic              after_store,
  input  logic [SLOT_W-1:0] slot_q,
  output logic              pad_valid,
  output logic [SLOT_W-1:0] pad_q
);
  localparam logic [SLOT_W-1:0] FILL_V   = SLOT_W'(FILL_TO);
  localparam logic [SLOT_W-1:0] NOPCLR_V = SLOT_W'(NOP_CLEAR_AT);

  logic [SLOT_W-1:0] pad_d;

  always_comb begin
    pad_d = '0;
    if (query_v && after_store && slot_q < NOPCLR_V)
      pad_d = term_mode ? SLOT_W'(1) : (slot_q < FILL_V ? FILL_V - slot_q : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_q     <= '0;
      pad_valid <= 1'b0;
    end else begin
      pad_q     <= pad_d;
      pad_valid <= query_v;
    end
  end

  AST_PAD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !query_v |=> pad_q == '0 && !pad_valid);  // R9
  AST_PAD_TERM_ONE: assert property (@(posedge clk) disable iff (rst)
    query_v && after_store && term_mode && slot_q < NOPCLR_V |=> pad_q == SLOT_W'(1));  // R9
  AST_PAD_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    query_v && !after_store |=> pad_valid && pad_q == '0);  // R9
endmodule

// File: rtl/dgt_tracker.sv
module dgt_tracker
  import dgt_pkg::*;
#(
  parameter int SLOT_W       = 3,
  parameter int BR_W         = 2,
  parameter int FULL_AT      = 5,
  parameter int NOP_CLEAR_AT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              term_nop_mode,
  input  logic              ins_valid,
  input  logic [CLS_W-1:0]  ins_class,
  input  logic              ins_record,
  input  logic              ins_branch,
  input  logic              ins_after_store,
  input  logic              nop_valid,
  input  logic              query_valid,
  output logic              must_lead,
  output logic              prefer_other,
  output logic [SLOT_W-1:0] slot_count,
  output logic [BR_W-1:0]   branch_count,
  output logic              pad_valid,
  output logic [SLOT_W-1:0] pad_count
);
  ins_desc_t         desc;
  logic [SLOT_W-1:0] weight;

  assign desc = '{cls: ins_class, record: ins_record,
                  branch: ins_branch, after_store: ins_after_store};

  dgt_classify #(.SLOT_W(SLOT_W)) u_classify (
    .cls    (desc.cls),
    .record (desc.record),
    .weight (weight),
    .lead   (must_lead)
  );

  dgt_group_state #(
    .SLOT_W(SLOT_W), .BR_W(BR_W), .FULL_AT(FULL_AT), .NOP_CLEAR_AT(NOP_CLEAR_AT)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .term_mode  (term_nop_mode),
    .ins_v      (ins_valid),
    .ins_weight (weight),
    .ins_lead   (must_lead),
    .ins_branch (desc.branch),
    .nop_v      (nop_valid),
    .slot_q     (slot_count),
    .br_q       (branch_count)
  );

  dgt_pad_calc #(
    .SLOT_W(SLOT_W), .FILL_TO(FULL_AT), .NOP_CLEAR_AT(NOP_CLEAR_AT)
  ) u_pad (
    .clk         (clk),
    .rst         (rst),
    .term_mode   (term_nop_mode),
    .query_v     (query_valid),
    .after_store (desc.after_store),
    .slot_q      (slot_count),
    .pad_valid   (pad_valid),
    .pad_q       (pad_count)
  );

  assign prefer_other = must_lead && (slot_count != '0);

  AST_WEIGHT_LEAD: assert property (@(posedge clk) disable iff (rst)
    ins_valid && !must_lead && slot_count < SLOT_W'(FULL_AT) && !(ins_branch && branch_count != '0)
    |=> slot_count == $past(slot_count) + 1'b1);  // R4
endmodule

// File: tb/dgt_tracker_tb.sv
module dgt_tracker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic term, iv, rec, br, las, nv, qv;
  logic [3:0] cls;
  logic must_lead, prefer_other, pad_valid;
  logic [2:0] slot_count, pad_count;
  logic [1:0] branch_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ms = 0, mb = 0, mpad = 0, mpv = 0;

  always #4 clk = ~clk;

  dgt_tracker u_dut (
    .clk(clk), .rst(rst), .term_nop_mode(term), .ins_valid(iv), .ins_class(cls),
    .ins_record(rec), .ins_branch(br), .ins_after_store(las), .nop_valid(nv),
    .query_valid(qv), .must_lead(must_lead), .prefer_other(prefer_other),
    .slot_count(slot_count), .branch_count(branch_count), .pad_valid(pad_valid),
    .pad_count(pad_count)
  );

  function automatic int mw(int c, bit r);
    int w;
    case (c)
      1, 2:    w = 2;
      3, 4, 5: w = 4;
      default: w = 1;
    endcase
    if (w == 1 && r) w = 2;
    return w;
  endfunction

  function automatic bit mlead(int c, bit r);
    return mw(c, r) > 1 || c == 6 || c == 7 || c == 8;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic step(bit iv_, int c, bit r, bit b, bit l, bit nv_, bit q, bit t, string tag);
    iv = iv_; cls = 4'(c); rec = r; br = b; las = l; nv = nv_; qv = q; term = t;
    #1;
    chk(must_lead == mlead(c, r), "R4 must_lead", int'(must_lead), int'(mlead(c, r)));
    chk(prefer_other == (mlead(c, r) && ms != 0), "R5 prefer_other",
        int'(prefer_other), int'(mlead(c, r) && ms != 0));
    mpv  = q;
    mpad = (q && l && ms < 6) ? (t ? 1 : 5 - ms) : 0;
    if (iv_) begin
      if (ms == 5 || (b && mb != 0)) begin
        ms = 0; mb = 0;
      end else begin
        if (mlead(c, r) && ms != 0) begin ms = 0; mb = 0; end
        ms = ms + mw(c, r); if (ms > 7) ms = 7;
        if (b && mb < 3) mb++;
      end
    end else if (nv_) begin
      if (t || ms == 6) begin ms = 0; mb = 0; end
      else if (ms < 7) ms++;
    end
    @(posedge clk);
    @(negedge clk);
    iv = 0; nv = 0; qv = 0;
    chk(int'(slot_count) == ms, {tag, " slot_count"}, int'(slot_count), ms);
    chk(int'(branch_count) == mb, {tag, " branch_count"}, int'(branch_count), mb);
    chk(int'(pad_count) == mpad, "R9 pad_count", int'(pad_count), mpad);
    chk(int'(pad_valid) == mpv, "R9 pad_valid", int'(pad_valid), mpv);
  endtask

  task automatic do_reset();
    rst = 1; iv = 0; nv = 0; qv = 0; term = 0; cls = 0; rec = 0; br = 0; las = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    ms = 0; mb = 0; mpad = 0; mpv = 0;
    chk(slot_count == 0, "R1 slot_count", int'(slot_count), 0);
    chk(branch_count == 0, "R1 branch_count", int'(branch_count), 0);
    chk(pad_count == 0 && pad_valid == 0, "R1 pad", int'(pad_count), 0);
  endtask

  // Plain one-slot non-branch instruction.
  task automatic plain(string tag);
    step(1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    term = 0; iv = 0; nv = 0; qv = 0; cls = 0; rec = 0; br = 0; las = 0;
    @(negedge clk);
    do_reset();

    // R2 R3 R4: each class, both record settings, from an empty group.
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 2; r++) begin
        do_reset();
        step(1, c, r[0], 0, 0, 0, 0, 0, r[0] ? "R3" : "R2");
        // R5 R7: same descriptor again against a nonempty group.
        step(1, c, r[0], 0, 0, 0, 0, 0, "R7");
      end

    // R6: full group wraps, instruction not counted.
    do_reset();
    for (int i = 0; i < 5; i++) plain("R8");
    step(1, 3, 0, 0, 0, 0, 0, 0, "R6");
    // R6: second branch wraps.
    do_reset();
    step(1, 0, 0, 1, 0, 0, 0, 0, "R8");
    plain("R8");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R6");

    // R9: pad counts for every slot level, both modes, with and without conflict.
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 2; t++)
        for (int l = 0; l < 2; l++) begin
          do_reset();
          for (int k = 0; k < s && k < 6; k++) step(0, 0, 0, 0, 0, 1, 0, 0, "R10");
          if (s == 7) plain("R8");
          step(0, 0, 0, 0, l[0], 0, 1, t[0], "R9");
        end

    // R10: no-op at 6 wraps, at 7 saturates, terminating mode clears.
    do_reset();
    for (int k = 0; k < 7; k++) step(0, 0, 0, 0, 0, 1, 0, 0, "R10");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 1, 0, 0, "R10");
    plain("R8");
    plain("R8");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 0, 1, "R10");

    // R11: both strobes, and idle hold.
    do_reset();
    plain("R8");
    step(1, 0, 0, 0, 0, 1, 0, 1, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 5, 1, 1, 1, 0, 0, 1, "R11");

    // Mixed pseudo-random sweep.
    begin
      logic [15:0] lf = 16'hACE1;
      do_reset();
      for (int n = 0; n < 4000; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[15:12] == 4'hF) do_reset();
        else step(lf[0] | lf[1], int'(lf[5:2]), lf[6] & lf[7], lf[8] & lf[9],
                  lf[10], lf[11] | ~lf[0], lf[12] ^ lf[3], lf[13] & lf[14], "R8");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule